// File: doc/BRIEF.md
# Bidirectional Mailbox Register File

This block is a small register file that sits between two agents, a host and a management controller, so that they can pass short messages to each other. Both agents see the same sixteen 8-bit data registers. By convention register 0 carries a command, register 1 a sequence number, registers 2 to 12 arguments, register 13 a response code, register 14 a status byte owned by the host and register 15 a status byte owned by the controller. The block gives no meaning to these bytes and treats all sixteen alike.

Each agent has its own register-access port and its own interrupt output. An agent can ring a doorbell toward its peer through its control register. The peer sees the doorbell as a pending flag in the top bit of its own control register and as its interrupt line. Each agent can also ask to be interrupted whenever its peer writes selected data registers. It does this through an enable bitmap with one bit per data register and a mask bitmap that keeps recorded events off the interrupt line.

Top module: `mbx_regfile`

Address map, the same on both ports: 0 to 15 are the data registers. 16 is this port's control register. 17 and 18 are the write-interrupt enable bitmap: address 17 bit i is register i, and address 18 bit i is register 8+i. 19 and 20 are the mask bitmap, with the same layout. 21 and 22 are the write-interrupt pending bitmap, with the same layout. Addresses 23 to 31 are unused.

## Requirements
- R1: Every data register (addresses 0 to 15) can be written from either port and read back from either port. Read data appears on the port's rdata one clock after the read strobe and holds until that port's next read.
- R2: A write to address 16 with bit 0 set raises the peer's doorbell. The peer's control register then reads 0x80 (bit 7 set) and the peer's interrupt output asserts. The writer's own control register is unchanged.
- R3: A port clears its own bit 7 by writing address 16 with bit 7 set. Its interrupt then deasserts if no other source is pending. If a peer doorbell and a clear arrive in the same cycle, the bit stays set.
- R4: When a port's enable bit for data register i is 1, a write by the peer to register i sets that port's pending bit i. Writes to registers whose enable bit is 0 set nothing. A port's own data writes never set its own pending bits.
- R5: A mask bit of 1 keeps the matching pending bit off the interrupt output but does not stop the pending bit being recorded. Clearing the mask bit while the pending bit is still set asserts the interrupt.
- R6: Writing 1s to address 21 or 22 clears the matching pending bits. Bits written as 0 are left unchanged.
- R7: The interrupt output is registered. It is the OR of the doorbell bit and all pending bits that are not masked, and it changes one clock after the state that drives it changes.
- R8: When both ports write the same data register in the same cycle, the controller's value is stored. Both writes still count as write events for the peer's pending bits.
- R9: After reset, all registers, both read-data outputs and both interrupt outputs are zero.
- R10: Addresses 23 to 31 read as 0 and writes to them have no effect. Control register bits 1 to 6 read as 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host access is a write (1) or a read (0) |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| h_irq | output | 1 | Interrupt toward the host |
| c_sel | input | 1 | Controller access strobe |
| c_wr | input | 1 | Controller access is a write (1) or a read (0) |
| c_addr | input | 5 | Controller register address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, registered |
| c_irq | output | 1 | Interrupt toward the controller |

## Verification
The data path is driven with a distinct byte in every register, written from one side and read from the other. This exposes any address aliasing or lane swap. Doorbells are rung in both directions and then cleared, and the interrupt is sampled both in the cycle right after the write and one cycle later, so that a missing output register or a missing clear can be told apart. Write-triggered events are tried on an enabled register, a neighbouring register that is not enabled, and the receiver's own write, and then with the mask set and released. This separates the effect of the enable from the effect of the mask. Same-cycle collisions, a doorbell arriving together with a clear, and unused addresses cover the priority rules and the cases where a write must have no effect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // number of bitmap bytes needed to give each data register one bit
  function automatic int bank_count(input int nregs, input int dw);
    return (nregs + dw - 1) / dw;
  endfunction

  function automatic int ctrl_ofs(input int nregs);
    return nregs;
  endfunction

  function automatic int en_ofs(input int nregs);
    return nregs + 1;
  endfunction

  function automatic int mask_ofs(input int nregs, input int nb);
    return nregs + 1 + nb;
  endfunction

  function automatic int pend_ofs(input int nregs, input int nb);
    return nregs + 1 + 2 * nb;
  endfunction

  function automatic int map_size(input int nregs, input int nb);
    return nregs + 1 + 3 * nb;
  endfunction

endpackage

// File: rtl/mbx_data_bank.sv
// Shared data registers with two write ports; controller port has priority.
module mbx_data_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       h_we,
  input  logic [IDX_W-1:0]           h_idx,
  input  logic [DATA_W-1:0]          h_wd,
  input  logic                       c_we,
  input  logic [IDX_W-1:0]           c_idx,
  input  logic [DATA_W-1:0]          c_wd,
  output logic [NUM_REGS*DATA_W-1:0] vals
);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              h_blocked;

  assign h_blocked = c_we && (c_idx == h_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      if (h_we && !h_blocked) mem[h_idx] <= h_wd;
      if (c_we)               mem[c_idx] <= c_wd;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
      assign vals[g*DATA_W +: DATA_W] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/mbx_side_ctl.sv
// One agent's view: address decode, doorbell flag, write-event bitmaps,
// registered read mux and registered interrupt.
module mbx_side_ctl
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 5,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_REGS*DATA_W-1:0] vals,
  input  logic                       peer_bell,
  input  logic [NUM_REGS-1:0]        peer_hit,
  output logic                       data_we,
  output logic [NUM_REGS-1:0]        own_hit,
  output logic                       bell_ring,
  output logic [DATA_W-1:0]          rdata,
  output logic                       irq
);

  localparam int NB     = bank_count(NUM_REGS, DATA_W);
  localparam int BMW    = NB * DATA_W;
  localparam int CTRL_A = ctrl_ofs(NUM_REGS);
  localparam int EN_A   = en_ofs(NUM_REGS);
  localparam int MK_A   = mask_ofs(NUM_REGS, NB);
  localparam int PD_A   = pend_ofs(NUM_REGS, NB);

  logic acc_wr, acc_rd, ctrl_wr;
  logic bell_q;

  logic [DATA_W-1:0] en_q   [NB];
  logic [DATA_W-1:0] mask_q [NB];
  logic [BMW-1:0]    en_flat, mask_flat, clr_flat;
  logic [NUM_REGS-1:0] pend_q;
  logic [BMW-1:0]    pend_flat;
  logic [DATA_W-1:0] rd_val;

  assign acc_wr    = sel & wr;
  assign acc_rd    = sel & ~wr;
  assign data_we   = acc_wr && (addr < ADDR_W'(NUM_REGS));
  assign ctrl_wr   = acc_wr && (addr == ADDR_W'(CTRL_A));
  assign bell_ring = ctrl_wr && wdata[0];

  always_comb begin
    own_hit = '0;
    if (data_we) own_hit[addr[IDX_W-1:0]] = 1'b1;
  end

  // doorbell flag: a ring from the peer wins over a local clear
  always_ff @(posedge clk) begin
    if (rst)                             bell_q <= 1'b0;
    else if (peer_bell)                  bell_q <= 1'b1;
    else if (ctrl_wr && wdata[DATA_W-1]) bell_q <= 1'b0;
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q[b]   <= '0;
          mask_q[b] <= '0;
        end else begin
          if (acc_wr && addr == ADDR_W'(EN_A + b)) en_q[b]   <= wdata;
          if (acc_wr && addr == ADDR_W'(MK_A + b)) mask_q[b] <= wdata;
        end
      end
      assign en_flat[b*DATA_W +: DATA_W]   = en_q[b];
      assign mask_flat[b*DATA_W +: DATA_W] = mask_q[b];
      assign clr_flat[b*DATA_W +: DATA_W]  =
        (acc_wr && addr == ADDR_W'(PD_A + b)) ? wdata : '0;
    end
  endgenerate

  // pending events: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_flat[NUM_REGS-1:0])
                     | (peer_hit & en_flat[NUM_REGS-1:0]);
  end

  generate
    if (BMW > NUM_REGS) begin : g_pad
      assign pend_flat = {{(BMW-NUM_REGS){1'b0}}, pend_q};
    end else begin : g_nopad
      assign pend_flat = pend_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= bell_q | (|(pend_q & ~mask_flat[NUM_REGS-1:0]));
  end

  always_comb begin
    rd_val = '0;
    if (addr < ADDR_W'(NUM_REGS)) begin
      rd_val = vals[addr[IDX_W-1:0]*DATA_W +: DATA_W];
    end else if (addr == ADDR_W'(CTRL_A)) begin
      rd_val = {bell_q, {(DATA_W-1){1'b0}}};
    end
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(EN_A + b)) rd_val = en_flat[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(MK_A + b)) rd_val = mask_flat[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(PD_A + b)) rd_val = pend_flat[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (acc_rd) rdata <= rd_val;
  end

endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   =
    $clog2(map_size(NUM_REGS, bank_count(NUM_REGS, DATA_W)))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_sel,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_irq,
  input  logic              c_sel,
  input  logic              c_wr,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_irq
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS*DATA_W-1:0] vals;
  logic                       h_we, c_we, h_ring, c_ring;
  logic [NUM_REGS-1:0]        h_hit, c_hit;

  mbx_data_bank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) i_bank (
    .clk(clk), .rst(rst),
    .h_we(h_we), .h_idx(h_addr[IDX_W-1:0]), .h_wd(h_wdata),
    .c_we(c_we), .c_idx(c_addr[IDX_W-1:0]), .c_wd(c_wdata),
    .vals(vals)
  );

  mbx_side_ctl #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) i_host (
    .clk(clk), .rst(rst),
    .sel(h_sel), .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
    .vals(vals), .peer_bell(c_ring), .peer_hit(c_hit),
    .data_we(h_we), .own_hit(h_hit), .bell_ring(h_ring),
    .rdata(h_rdata), .irq(h_irq)
  );

  mbx_side_ctl #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .sel(c_sel), .wr(c_wr), .addr(c_addr), .wdata(c_wdata),
    .vals(vals), .peer_bell(h_ring), .peer_hit(h_hit),
    .data_we(c_we), .own_hit(c_hit), .bell_ring(c_ring),
    .rdata(c_rdata), .irq(c_irq)
  );

endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              h_sel,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic [DATA_W-1:0] h_wdata,
  input logic [DATA_W-1:0] h_rdata,
  input logic              h_irq,
  input logic              c_sel,
  input logic              c_wr,
  input logic [ADDR_W-1:0] c_addr,
  input logic [DATA_W-1:0] c_wdata,
  input logic [DATA_W-1:0] c_rdata,
  input logic              c_irq
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_REGS);

  // R2: a peer doorbell shows on the interrupt two edges later
  p_bell_c2h_r2: assert property (@(posedge clk) disable iff (rst)
    (c_sel && c_wr && c_addr == CTRL_A && c_wdata[0]) |-> ##2 h_irq);

  p_bell_h2c_r2: assert property (@(posedge clk) disable iff (rst)
    (h_sel && h_wr && h_addr == CTRL_A && h_wdata[0]) |-> ##2 c_irq);

  // R9: reset leaves outputs quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!h_irq && !c_irq && h_rdata == '0 && c_rdata == '0));

  // R8: controller value survives a same-cycle collision
  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    (h_sel && h_wr && c_sel && c_wr && h_addr == c_addr &&
     h_addr < ADDR_W'(NUM_REGS))
    ##1 (c_sel && !c_wr && c_addr == $past(c_addr))
    |=> c_rdata == $past(c_wdata, 2));

  // R1: read data holds between reads
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(h_sel && !h_wr) |=> $stable(h_rdata));

  p_crd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(c_sel && !c_wr) |=> $stable(c_rdata));

endmodule

bind mbx_regfile mbx_regfile_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_mbx_regfile.sv
module test_mbx_regfile;

  localparam int DW = 8;
  localparam int NR = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_sel = 1'b0, h_wr = 1'b0, c_sel = 1'b0, c_wr = 1'b0;
  logic [AW-1:0] h_addr = '0, c_addr = '0;
  logic [DW-1:0] h_wdata = '0, c_wdata = '0;
  logic [DW-1:0] h_rdata, c_rdata;
  logic          h_irq, c_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_regfile i_mbx_regfile (
    .clk(clk), .rst(rst),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .c_sel(c_sel), .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_irq(c_irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic hwr(input int a, input logic [DW-1:0] d);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = AW'(a); h_wdata = d;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic cwr(input int a, input logic [DW-1:0] d);
    c_sel = 1'b1; c_wr = 1'b1; c_addr = AW'(a); c_wdata = d;
    @(negedge clk);
    c_sel = 1'b0; c_wr = 1'b0;
  endtask

  task automatic both_wr(input int ha, input logic [DW-1:0] hd,
                         input int ca, input logic [DW-1:0] cd);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = AW'(ha); h_wdata = hd;
    c_sel = 1'b1; c_wr = 1'b1; c_addr = AW'(ca); c_wdata = cd;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0; c_sel = 1'b0; c_wr = 1'b0;
  endtask

  task automatic hrd(input int a, output logic [DW-1:0] d);
    h_sel = 1'b1; h_wr = 1'b0; h_addr = AW'(a);
    @(negedge clk);
    h_sel = 1'b0;
    d = h_rdata;
  endtask

  task automatic crd(input int a, output logic [DW-1:0] d);
    c_sel = 1'b1; c_wr = 1'b0; c_addr = AW'(a);
    @(negedge clk);
    c_sel = 1'b0;
    d = c_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R9", "h_irq after reset", 32'(h_irq), 0);
    check("R9", "c_irq after reset", 32'(c_irq), 0);
    check("R9", "h_rdata after reset", 32'(h_rdata), 0);
    hrd(7, v);  check("R9", "data reg 7", 32'(v), 0);
    crd(16, v); check("R9", "ctrl reg", 32'(v), 0);
    hrd(17, v); check("R9", "enable reg", 32'(v), 0);
  endtask

  task automatic t_data();
    logic [DW-1:0] v;
    hwr(5, 8'hA5);
    crd(5, v);  check("R1", "host to ctrl reg 5", 32'(v), 32'hA5);
    cwr(15, 8'h3C);
    hrd(15, v); check("R1", "ctrl to host reg 15", 32'(v), 32'h3C);
    cycle();
    check("R1", "rdata held", 32'(h_rdata), 32'h3C);
    for (int i = 0; i < NR; i++) hwr(i, DW'((i * 17) ^ 8'h5A));
    for (int i = 0; i < NR; i++) begin
      crd(i, v);
      check("R1", $sformatf("pattern reg %0d", i), 32'(v),
            32'(DW'((i * 17) ^ 8'h5A)));
    end
    check("R4", "no pending from data writes", 32'(h_irq | c_irq), 0);
  endtask

  task automatic t_bell();
    logic [DW-1:0] v;
    hwr(16, 8'h01);
    check("R7", "c_irq not yet", 32'(c_irq), 0);
    cycle();
    check("R2", "c_irq after ring", 32'(c_irq), 1);
    check("R2", "h_irq untouched", 32'(h_irq), 0);
    crd(16, v); check("R2", "ctrl bit7", 32'(v), 32'h80);
    hrd(16, v); check("R2", "host ctrl unchanged", 32'(v), 0);
    cwr(16, 8'h80);
    check("R7", "c_irq held one cycle", 32'(c_irq), 1);
    cycle();
    check("R3", "c_irq after clear", 32'(c_irq), 0);
    crd(16, v); check("R3", "ctrl bit7 cleared", 32'(v), 0);
    cwr(16, 8'h01);
    cycle();
    check("R2", "h_irq after ring", 32'(h_irq), 1);
    hwr(16, 8'h80);
    cycle();
    check("R3", "h_irq after clear", 32'(h_irq), 0);
    // ring and clear in the same cycle: set wins
    both_wr(16, 8'h01, 16, 8'h80);
    crd(16, v); check("R3", "ring beats clear", 32'(v), 32'h80);
    check("R3", "c_irq stays", 32'(c_irq), 1);
    cwr(16, 8'h80);
    cycle();
    check("R3", "c_irq final", 32'(c_irq), 0);
  endtask

  task automatic t_wtrig();
    logic [DW-1:0] v;
    hwr(18, 8'h01);              // host watches register 8
    cwr(9, 8'h77);
    cycle();
    check("R4", "reg 9 not enabled", 32'(h_irq), 0);
    hrd(22, v); check("R4", "pending after reg 9", 32'(v), 0);
    cwr(8, 8'h66);
    cycle();
    check("R4", "h_irq after reg 8", 32'(h_irq), 1);
    hrd(22, v); check("R4", "pending bit 8", 32'(v), 32'h01);
    hwr(8, 8'h55);
    crd(22, v); check("R4", "own write no peer pending", 32'(v), 0);
    hwr(22, 8'h00);
    hrd(22, v); check("R6", "write 0 keeps pending", 32'(v), 32'h01);
    hwr(22, 8'h01);
    hrd(22, v); check("R6", "pending cleared", 32'(v), 0);
    check("R6", "h_irq after clear", 32'(h_irq), 0);
    // controller watching host writes
    cwr(17, 8'h10);
    hwr(4, 8'h12);
    cycle();
    check("R4", "c_irq from host write", 32'(c_irq), 1);
    crd(21, v); check("R4", "ctrl pending bit 4", 32'(v), 32'h10);
    cwr(21, 8'h10);
    cwr(17, 8'h00);
    cycle();
    check("R6", "c_irq after clear", 32'(c_irq), 0);
    hwr(18, 8'h00);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    hwr(17, 8'h04);
    hwr(19, 8'h04);
    cwr(2, 8'h99);
    cycle(); cycle();
    check("R5", "masked irq", 32'(h_irq), 0);
    hrd(21, v); check("R5", "pending recorded", 32'(v), 32'h04);
    hwr(19, 8'h00);
    cycle();
    check("R5", "unmasked irq", 32'(h_irq), 1);
    hwr(21, 8'h04);
    hwr(17, 8'h00);
    check("R5", "irq after clear", 32'(h_irq), 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    hwr(17, 8'h08);
    cwr(17, 8'h08);
    both_wr(3, 8'h11, 3, 8'h22);
    hrd(3, v); check("R8", "host sees ctrl value", 32'(v), 32'h22);
    crd(3, v); check("R8", "ctrl sees ctrl value", 32'(v), 32'h22);
    hrd(21, v); check("R8", "host pending from ctrl write", 32'(v), 32'h08);
    crd(21, v); check("R8", "ctrl pending from host write", 32'(v), 32'h08);
    check("R8", "both irqs", 32'({h_irq, c_irq}), 32'h3);
    both_wr(21, 8'h08, 21, 8'h08);
    both_wr(17, 8'h00, 17, 8'h00);
    cycle();
    check("R8", "irqs cleared", 32'({h_irq, c_irq}), 0);
  endtask

  task automatic t_unused();
    logic [DW-1:0] v;
    hwr(25, 8'hFF);
    hrd(25, v); check("R10", "unused addr 25", 32'(v), 0);
    crd(31, v); check("R10", "unused addr 31", 32'(v), 0);
    hwr(16, 8'h7E);
    cycle();
    check("R10", "no ring from bits 1-6", 32'(c_irq), 0);
    hrd(16, v); check("R10", "host ctrl reads 0", 32'(v), 0);
    crd(16, v); check("R10", "ctrl ctrl reads 0", 32'(v), 0);
    crd(5, v);  check("R10", "data untouched", 32'(v), 32'(DW'((5 * 17) ^ 8'h5A)));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cycle();
    t_reset();
    t_data();
    t_bell();
    t_wtrig();
    t_mask();
    t_collide();
    t_unused();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule